// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Deferred Pending

This block collects level-sensitive interrupt sources into groups of 32 lines and gives each group one output interrupt toward a parent controller. A rising edge on any line of a group starts an evaluation. The block ANDs the currently active lines of that group with the group's enable set. If nothing survives, nothing happens. If the group is idle and unmasked, the surviving lines are loaded into the group's status register and the group output goes high. If the group is busy servicing or has a mask in force, the lines are merged into a hidden pending register instead.

Firmware acknowledges sources by writing ones to the status register. When a clear empties status, any pending sources are promoted into status and the output stays high. With nothing pending, the output drops. Writing all ones is an initialization clear. It empties status but leaves the output and the pending register as they were. The enable register has a dual role. A write that carries new bits grows the sticky enable set. A write that carries no new bits is compared with the previously written value: if it raises some bit it unmasks the changed bits, and otherwise it masks them.

Each group runs a three-state machine. GRP_QUIET means the output is low and status is empty. GRP_SERVICE means the output is high and status holds sources. GRP_HELD means the output is high and status was emptied by an initialization clear. The transitions are:
- launch: QUIET or HELD to SERVICE.
- promote: QUIET, SERVICE or HELD to SERVICE, when pending is loaded into status.
- partial clear: SERVICE stays in SERVICE.
- drain: SERVICE or HELD to QUIET.
- init clear: SERVICE to HELD, or to SERVICE when a launch arrives in the same cycle.

Top module: `intc_aggr`

## Requirements
- R1: After reset every enable, status and storage word reads as zero and all group outputs are low.
- R2: A rising source line in group g with select = (active lines AND enable set) nonzero loads status with select and drives output g high, provided status and mask of g are both zero. Group g's enable register sits at byte offset g*0x100 and its status register at g*0x100+4.
- R3: A rising source line whose select is zero changes neither status nor the output.
- R4: A rising source line with nonzero select, while status or mask of the group is nonzero, ORs select into pending and leaves status and the output unchanged.
- R5: A status write clears the bits that are one in the data. When this leaves status zero, a nonzero pending is moved into status, pending is emptied and the output stays high. With pending zero the output goes low.
- R6: A status write of zero has no effect at all.
- R7: A status write of all ones empties status but leaves the output and pending unchanged. A later nonzero clear then runs the drain step of R5.
- R8: An enable write that adds bits ORs them into the sticky enable set, stores the data as the readable value and leaves the mask unchanged.
- R9: An enable write that adds no bits, where change = (stored value XOR data) and change AND data is zero, sets the changed bits in the mask. A nonzero mask diverts new events to pending.
- R10: An enable write that adds no bits, where change AND data is nonzero, clears the changed bits from the mask.
- R11: An enable write of zero while the enable set is zero only stores zero.
- R12: Only a rising source edge starts an evaluation. A falling line or a line held high does not.
- R13: When a status clear and a source event reach the same group in one cycle, the clear is applied first and the event is merged afterwards, so no source is lost.
- R14: Aligned words at offsets g*0x100+8 and +0xC are plain storage. Unaligned accesses, other offsets and groups beyond the last read zero and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lines | input | NUM_GROUPS*LINES | Level source lines; group g occupies bits g*LINES and up |
| irq_out | output | NUM_GROUPS | One interrupt output per group |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Registered read data |

## Verification
The bench targets deferral and promotion. A design that dropped events arriving during service, or that lowered the output when status drained with sources pending, would lose those sources. It separates the all-ones initialization clear from an ordinary clear: treating the two alike would drop the output early or empty pending. The enable-register decoding is exercised by mask, unmask and growth sequences, since a design that recomputed the mask on a growing write, or let a mask-only write shrink the enable set, would leave sources stuck in pending. It also aims a clear and a new edge at the same cycle, and holds lines high after acknowledgement to catch level retriggering.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Per-group service state
    typedef enum logic [1:0] {
        GRP_QUIET   = 2'd0,
        GRP_SERVICE = 2'd1,
        GRP_HELD    = 2'd2
    } grp_state_e;

    // Outcome of a status-register write in the current cycle
    typedef enum logic [2:0] {
        SK_NONE    = 3'd0,
        SK_INIT    = 3'd1,
        SK_PARTIAL = 3'd2,
        SK_PROMOTE = 3'd3,
        SK_IDLE    = 3'd4
    } st_kind_e;

    // Word slots inside one group window
    localparam int WORD_ENABLE  = 0;
    localparam int WORD_STATUS  = 1;
    localparam int WORD_STORE0  = 2;

endpackage

// File: rtl/intc_src_sync.sv
module intc_src_sync #(
    parameter int LINES  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_lines,
    output logic [LINES-1:0] lvl,
    output logic             rise_any
);

    logic [STAGES-1:0][LINES-1:0] pipe_q;
    logic [LINES-1:0]             prev_q;

    // Synchronizer chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= raw_lines;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    // Previous synchronized level for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign lvl      = pipe_q[STAGES-1];
    assign rise_any = |(pipe_q[STAGES-1] & ~prev_q);

endmodule

// File: rtl/intc_group.sv
module intc_group
    import intc_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    input  logic             ev,
    input  logic             en_wr,
    input  logic             st_wr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] en_reg,
    output logic [LINES-1:0] status,
    output logic [LINES-1:0] pend,
    output logic             irq
);

    localparam logic [LINES-1:0] ALL_ONES = '1;

    grp_state_e       state_q, state_n;
    st_kind_e         kind;
    logic [LINES-1:0] status_q, status_n;
    logic [LINES-1:0] pend_q, pend_n;
    logic [LINES-1:0] en_reg_q, en_reg_n;
    logic [LINES-1:0] en_set_q, en_set_n;
    logic [LINES-1:0] mask_q, mask_n;
    logic [LINES-1:0] sel;
    logic [LINES-1:0] cleared;
    logic [LINES-1:0] st_mid;
    logic [LINES-1:0] pend_mid;
    logic [LINES-1:0] en_grow;
    logic [LINES-1:0] en_chg;
    logic             launch;
    logic             defer;

    // Classify the status write of this cycle
    always_comb begin
        cleared = status_q & ~wdata;
        kind    = SK_NONE;
        if (st_wr && (wdata != '0)) begin
            if (wdata == ALL_ONES) begin
                kind = SK_INIT;
            end else if (cleared != '0) begin
                kind = SK_PARTIAL;
            end else if (pend_q != '0) begin
                kind = SK_PROMOTE;
            end else begin
                kind = SK_IDLE;
            end
        end
    end

    // Status and pending after the clear, before the event merge
    always_comb begin
        st_mid   = status_q;
        pend_mid = pend_q;
        unique case (kind)
            SK_NONE:    st_mid = status_q;
            SK_INIT:    st_mid = '0;
            SK_PARTIAL: st_mid = cleared;
            SK_PROMOTE: begin
                st_mid   = pend_q;
                pend_mid = '0;
            end
            SK_IDLE:    st_mid = '0;
            default:    st_mid = status_q;
        endcase
    end

    // Event merge: uses the enable set and mask as they stood before this cycle
    always_comb begin
        sel      = lvl & en_set_q;
        launch   = 1'b0;
        defer    = 1'b0;
        status_n = st_mid;
        pend_n   = pend_mid;
        if (ev && (sel != '0)) begin
            if ((mask_q != '0) || (st_mid != '0)) begin
                defer  = 1'b1;
                pend_n = pend_mid | sel;
            end else begin
                launch   = 1'b1;
                status_n = sel;
            end
        end
    end

    // Enable register: grow, mask or unmask
    always_comb begin
        en_reg_n = en_reg_q;
        en_set_n = en_set_q;
        mask_n   = mask_q;
        en_grow  = en_set_q | wdata;
        en_chg   = en_reg_q ^ wdata;
        if (en_wr) begin
            en_reg_n = wdata;
            if ((wdata == '0) && (en_set_q == '0)) begin
                en_set_n = en_set_q;
            end else if (en_grow != en_set_q) begin
                en_set_n = en_grow;
            end else if ((en_chg & wdata) != '0) begin
                mask_n = mask_q & ~en_chg;
            end else begin
                mask_n = mask_q | en_chg;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            GRP_QUIET: begin
                if (launch || (kind == SK_PROMOTE)) begin
                    state_n = GRP_SERVICE;
                end
            end
            GRP_SERVICE: begin
                if (launch) begin
                    state_n = GRP_SERVICE;
                end else if (kind == SK_INIT) begin
                    state_n = GRP_HELD;
                end else if (kind == SK_IDLE) begin
                    state_n = GRP_QUIET;
                end
            end
            GRP_HELD: begin
                if (launch || (kind == SK_PROMOTE)) begin
                    state_n = GRP_SERVICE;
                end else if (kind == SK_IDLE) begin
                    state_n = GRP_QUIET;
                end
            end
            default: state_n = GRP_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_QUIET;
        end else begin
            state_q <= state_n;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            pend_q   <= '0;
            en_reg_q <= '0;
            en_set_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_n;
            pend_q   <= pend_n;
            en_reg_q <= en_reg_n;
            en_set_q <= en_set_n;
            mask_q   <= mask_n;
        end
    end

    // Outputs
    always_comb begin
        irq    = (state_q != GRP_QUIET);
        en_reg = en_reg_q;
        status = status_q;
        pend   = pend_q;
    end

endmodule

// File: rtl/intc_regbus.sv
module intc_regbus
    import intc_pkg::*;
#(
    parameter int NUM_GROUPS  = 9,
    parameter int LINES       = 32,
    parameter int STORE_WORDS = 2,
    parameter int AW          = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [LINES-1:0]            bus_wdata,
    input  logic [NUM_GROUPS*LINES-1:0] en_flat,
    input  logic [NUM_GROUPS*LINES-1:0] st_flat,
    output logic [NUM_GROUPS-1:0]       en_wr,
    output logic [NUM_GROUPS-1:0]       st_wr,
    output logic [LINES-1:0]            bus_rdata
);

    localparam int GSEL_W = AW - 8;

    logic [GSEL_W-1:0] gsel;
    logic [5:0]        word;
    logic              aligned;
    logic [NUM_GROUPS-1:0][STORE_WORDS-1:0][LINES-1:0] store_q;
    logic [LINES-1:0]  rd_mux;

    assign gsel    = bus_addr[AW-1:8];
    assign word    = bus_addr[7:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // Per-group strobes and storage words
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit      = aligned && (int'(gsel) == g);
        assign en_wr[g] = bus_wr && hit && (int'(word) == WORD_ENABLE);
        assign st_wr[g] = bus_wr && hit && (int'(word) == WORD_STATUS);

        for (genvar w = 0; w < STORE_WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    store_q[g][w] <= '0;
                end else if (bus_wr && hit && (int'(word) == WORD_STORE0 + w)) begin
                    store_q[g][w] <= bus_wdata;
                end
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (int'(gsel) == g) begin
                    if (int'(word) == WORD_ENABLE) begin
                        rd_mux = en_flat[g*LINES +: LINES];
                    end else if (int'(word) == WORD_STATUS) begin
                        rd_mux = st_flat[g*LINES +: LINES];
                    end else begin
                        for (int w = 0; w < STORE_WORDS; w++) begin
                            if (int'(word) == WORD_STORE0 + w) begin
                                rd_mux = store_q[g][w];
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/intc_aggr.sv
module intc_aggr #(
    parameter int NUM_GROUPS  = 9,
    parameter int LINES       = 32,
    parameter int STORE_WORDS = 2,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*LINES-1:0] src_lines,
    output logic [NUM_GROUPS-1:0]       irq_out,
    input  logic [AW-1:0]               bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [LINES-1:0]            bus_wdata,
    output logic [LINES-1:0]            bus_rdata
);

    logic [NUM_GROUPS*LINES-1:0] grp_en;
    logic [NUM_GROUPS*LINES-1:0] grp_status;
    logic [NUM_GROUPS*LINES-1:0] grp_pend;
    logic [NUM_GROUPS*LINES-1:0] grp_lvl;
    logic [NUM_GROUPS-1:0]       grp_ev;
    logic [NUM_GROUPS-1:0]       en_wr;
    logic [NUM_GROUPS-1:0]       st_wr;

    intc_regbus #(
        .NUM_GROUPS  (NUM_GROUPS),
        .LINES       (LINES),
        .STORE_WORDS (STORE_WORDS),
        .AW          (AW)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .en_flat   (grp_en),
        .st_flat   (grp_status),
        .en_wr     (en_wr),
        .st_wr     (st_wr),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slice
        intc_src_sync #(
            .LINES  (LINES),
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_lines (src_lines[g*LINES +: LINES]),
            .lvl       (grp_lvl[g*LINES +: LINES]),
            .rise_any  (grp_ev[g])
        );

        intc_group #(
            .LINES (LINES)
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (grp_lvl[g*LINES +: LINES]),
            .ev     (grp_ev[g]),
            .en_wr  (en_wr[g]),
            .st_wr  (st_wr[g]),
            .wdata  (bus_wdata),
            .en_reg (grp_en[g*LINES +: LINES]),
            .status (grp_status[g*LINES +: LINES]),
            .pend   (grp_pend[g*LINES +: LINES]),
            .irq    (irq_out[g])
        );
    end

endmodule

// File: rtl/intc_aggr_chk.sv
module intc_aggr_chk #(
    parameter int NUM_GROUPS = 9,
    parameter int LINES      = 32,
    parameter int AW         = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [AW-1:0]               bus_addr,
    input logic                        bus_wr,
    input logic [LINES-1:0]            bus_wdata,
    input logic [NUM_GROUPS-1:0]       irq_out,
    input logic [NUM_GROUPS*LINES-1:0] grp_status,
    input logic [NUM_GROUPS*LINES-1:0] grp_pend,
    input logic [NUM_GROUPS-1:0]       grp_ev
);

    localparam logic [LINES-1:0] ALL_ONES = '1;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        logic hit_st;
        assign hit_st = bus_wr && (bus_addr[1:0] == 2'b00) && (bus_addr[7:2] == 6'd1)
                        && (int'(bus_addr[AW-1:8]) == g);

        assert_status_drives_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_status[g*LINES +: LINES] != '0) |-> irq_out[g]);

        assert_zero_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_st && (bus_wdata == '0) && !grp_ev[g])
            |=> ($stable(grp_status[g*LINES +: LINES]) && $stable(grp_pend[g*LINES +: LINES])
                 && $stable(irq_out[g])));

        assert_init_clear_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_st && (bus_wdata == ALL_ONES) && !grp_ev[g])
            |=> ((grp_status[g*LINES +: LINES] == '0) && $stable(irq_out[g])
                 && $stable(grp_pend[g*LINES +: LINES])));

        assert_drop_needs_no_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_out[g]) |-> ($past(grp_pend[g*LINES +: LINES]) == '0));

        assert_status_still_without_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!grp_ev[g] && !hit_st) |=> $stable(grp_status[g*LINES +: LINES]));
    end

endmodule

bind intc_aggr intc_aggr_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .LINES      (LINES),
    .AW         (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .irq_out    (irq_out),
    .grp_status (grp_status),
    .grp_pend   (grp_pend),
    .grp_ev     (grp_ev)
);

// File: tb/sim_intc_aggr.sv
`timescale 1ns/1ps
module sim_intc_aggr;

    localparam int NG = 9;
    localparam int L  = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*L-1:0] src = '0;
    logic [NG-1:0] irq_out;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [L-1:0]  bus_wdata = '0;
    logic [L-1:0]  bus_rdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    intc_aggr u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lines (src),
        .irq_out   (irq_out),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [AW-1:0] en_a(int g);
        return AW'(g * 256);
    endfunction

    function automatic logic [AW-1:0] st_a(int g);
        return AW'(g * 256 + 4);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic line(int g, int l, logic v);
        @(negedge clk);
        src[g*L + l] = v;
        settle();
    endtask

    task automatic chk_status(string tag, int g, logic [31:0] exp);
        logic [31:0] d;
        rd(st_a(g), d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int g = 0; g < NG; g += 8) begin
            rd(en_a(g), d);
            chk("R1 enable after reset", d, 0);
            rd(st_a(g), d);
            chk("R1 status after reset", d, 0);
            rd(AW'(g * 256 + 8), d);
            chk("R1 storage after reset", d, 0);
        end
        chk("R1 outputs after reset", 32'(irq_out), 0);
    endtask

    task automatic t_capture();
        wr(en_a(1), 32'h0000_00F0);
        line(1, 2, 1'b1);
        chk("R3 unenabled line output", 32'(irq_out[1]), 0);
        chk_status("R3 unenabled line status", 1, 0);
        @(negedge clk);
        src[L + 4] = 1'b1;
        src[L + 5] = 1'b1;
        settle();
        chk("R2 output raised", 32'(irq_out[1]), 1);
        chk_status("R2 status select", 1, 32'h30);
        chk("R2 other groups quiet", 32'(irq_out & ~9'h002), 0);
        wr(en_a(8), 32'h8000_0000);
        line(8, 31, 1'b1);
        chk("R2 last group output", 32'(irq_out[8]), 1);
        chk_status("R2 last group status", 8, 32'h8000_0000);
        wr(st_a(8), 32'h8000_0000);
        chk("R5 last group drained", 32'(irq_out[8]), 0);
        line(8, 31, 1'b0);
    endtask

    task automatic t_defer();
        line(1, 6, 1'b1);
        chk_status("R4 status kept while busy", 1, 32'h30);
        chk("R4 output kept", 32'(irq_out[1]), 1);
        wr(st_a(1), 32'h10);
        chk_status("R5 partial clear", 1, 32'h20);
        wr(st_a(1), 32'h20);
        chk_status("R5 pending promoted", 1, 32'h70);
        chk("R5 output held on promote", 32'(irq_out[1]), 1);
        wr(st_a(1), 32'h70);
        chk_status("R5 drained", 1, 0);
        chk("R5 output dropped", 32'(irq_out[1]), 0);
        @(negedge clk);
        src[L +: L] = '0;
        settle();
    endtask

    task automatic t_zero_write();
        wr(en_a(2), 32'h1);
        line(2, 0, 1'b1);
        wr(st_a(2), 32'h0);
        chk_status("R6 zero write status", 2, 32'h1);
        chk("R6 zero write output", 32'(irq_out[2]), 1);
        wr(st_a(2), 32'h1);
        chk("R6 later clear works", 32'(irq_out[2]), 0);
        line(2, 0, 1'b0);
    endtask

    task automatic t_init_clear();
        wr(en_a(3), 32'h3);
        line(3, 0, 1'b1);
        line(3, 1, 1'b1);
        wr(st_a(3), 32'hFFFF_FFFF);
        chk_status("R7 init clear status", 3, 0);
        chk("R7 init clear keeps output", 32'(irq_out[3]), 1);
        wr(st_a(3), 32'h1);
        chk_status("R7 pending survived init clear", 3, 32'h3);
        chk("R7 output after promote", 32'(irq_out[3]), 1);
        wr(st_a(3), 32'h3);
        chk("R7 final drain", 32'(irq_out[3]), 0);
        @(negedge clk);
        src[3*L +: L] = '0;
        settle();
    endtask

    task automatic t_enable_mask();
        logic [31:0] d;
        wr(en_a(4), 32'h0);
        rd(en_a(4), d);
        chk("R11 zero on empty set stored", d, 0);
        line(4, 0, 1'b1);
        chk("R11 nothing enabled", 32'(irq_out[4]), 0);
        line(4, 0, 1'b0);
        wr(en_a(4), 32'h0F);
        line(4, 0, 1'b1);
        chk_status("R8 growth leaves mask clear", 4, 32'h1);
        wr(st_a(4), 32'h1);
        line(4, 0, 1'b0);
        wr(en_a(4), 32'h03);
        rd(en_a(4), d);
        chk("R9 mask write stored", d, 32'h03);
        line(4, 3, 1'b1);
        chk("R9 masked event no output", 32'(irq_out[4]), 0);
        chk_status("R9 masked event no status", 4, 0);
        wr(en_a(4), 32'h0F);
        rd(en_a(4), d);
        chk("R10 unmask write stored", d, 32'h0F);
        chk("R10 unmask does not re-evaluate", 32'(irq_out[4]), 0);
        line(4, 0, 1'b1);
        chk_status("R10 unmasked launch", 4, 32'h09);
        chk("R10 output after unmask", 32'(irq_out[4]), 1);
        wr(st_a(4), 32'h09);
        chk_status("R8 sticky enable held pending", 4, 32'h08);
        wr(st_a(4), 32'h08);
        chk("R10 drained", 32'(irq_out[4]), 0);
        @(negedge clk);
        src[4*L +: L] = '0;
        settle();
    endtask

    task automatic t_edges();
        wr(en_a(5), 32'h1);
        line(5, 0, 1'b1);
        wr(st_a(5), 32'h1);
        settle();
        chk("R12 held level no retrigger", 32'(irq_out[5]), 0);
        line(5, 0, 1'b0);
        chk("R12 falling edge ignored", 32'(irq_out[5]), 0);
        chk_status("R12 falling edge status", 5, 0);
        line(5, 0, 1'b1);
        chk("R12 new rising edge", 32'(irq_out[5]), 1);
        wr(st_a(5), 32'h1);
        line(5, 0, 1'b0);
    endtask

    task automatic t_same_cycle();
        wr(en_a(6), 32'h3);
        line(6, 0, 1'b1);
        line(6, 0, 1'b0);
        chk_status("R13 setup status", 6, 32'h1);
        @(negedge clk);
        src[6*L + 1] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(st_a(6), 32'h1);
        settle();
        chk_status("R13 event kept after same-cycle clear", 6, 32'h2);
        chk("R13 output", 32'(irq_out[6]), 1);
        wr(st_a(6), 32'h2);
        line(6, 1, 1'b0);
    endtask

    task automatic t_storage();
        logic [31:0] d;
        wr(AW'(7*256 + 8), 32'hDEAD_BEEF);
        wr(AW'(7*256 + 12), 32'h0BAD_F00D);
        rd(AW'(7*256 + 8), d);
        chk("R14 storage word 0", d, 32'hDEAD_BEEF);
        rd(AW'(7*256 + 12), d);
        chk("R14 storage word 1", d, 32'h0BAD_F00D);
        wr(AW'(7*256 + 9), 32'h1234_5678);
        rd(AW'(7*256 + 8), d);
        chk("R14 unaligned write ignored", d, 32'hDEAD_BEEF);
        wr(AW'(7*256 + 16), 32'h5555_AAAA);
        rd(AW'(7*256 + 16), d);
        chk("R14 unmapped word reads zero", d, 0);
        wr(AW'(9*256), 32'hFFFF_0000);
        rd(AW'(9*256), d);
        chk("R14 group past last reads zero", d, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture();
        t_defer();
        t_zero_write();
        t_init_clear();
        t_enable_mask();
        t_edges();
        t_same_cycle();
        t_storage();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule